// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with a two-stage pipeline. The read and write paths have the same latency, so the shared data bus can carry a transfer on every cycle. A command is sampled on one rising edge. Its data slot is the bus cycle that ends two edges later. For a read, the memory drives the bus during that cycle. For a write, the host drives the bus during that cycle and the memory captures the word on the closing edge. The word is committed to the array on that same edge.

The block also provides the following:
- A four-beat burst mode with linear or interleaved address order.
- Three chip selects for depth expansion.
- An active-high stall input that freezes every register.
- Per-lane write masks, sampled together with the write data.
- An asynchronous output-enable gate.

A read that hits a write still in flight returns that write's merged lanes. The bidirectional bus is represented as `dq_in`, `dq_out` and `dq_drive`, so the pad-level tri-state buffer lives outside the block.

Top module: `zt_sram`

## Requirements
- R1: A read command sampled at edge k (load_n low, all chip selects active, wr_n high) drives `dq_drive`=1 and the addressed word on `dq_out` from just after edge k+1 until edge k+2, provided `out_en_n` is low.
- R2: A write command sampled at edge k takes its word from `dq_in` at edge k+2. A later read of that address returns the written lanes.
- R3: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle between them, and every transfer completes correctly.
- R4: `lane_wr_n[i]` (active low) is sampled at the data edge together with the write word. It enables writing of `dq_in[9*i+8:9*i]`: bit 0 controls bits 8:0 and bit 1 controls bits 17:9. A lane whose mask bit is high keeps its old contents.
- R5: A read whose array access coincides with the data edge of a write to the same address returns the write's enabled lanes merged with the stored lanes.
- R6: While `clk_hold` is high, all inputs are ignored and every register keeps its value, so `dq_out` and `dq_drive` stay unchanged.
- R7: With load_n low, an inactive chip select (`cs_a_n` high, `cs_b` low or `cs_c_n` high) starts no operation and ends any burst. The bus is released in that command's data slot. Operations issued earlier still complete.
- R8: In the data slot of a write command, `dq_drive` is 0.
- R9: A high `out_en_n` forces `dq_drive` to 0 at once, without a clock edge.
- R10: With load_n high during an active burst, the next beat keeps the burst's direction and changes only address bits 1:0. With `burst_ilv`=0 the beat index is added to the base (mod 4). With `burst_ilv`=1 the beat index is XORed with the base.
- R11: Chip selects are ignored when load_n is high. An advance while no burst is active starts nothing.
- R12: After reset, no operation is pending and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| clk_hold | input | 1 | High: freeze all registers and ignore inputs |
| addr | input | ADDR_W | Command address |
| wr_n | input | 1 | Low: write command, high: read command |
| load_n | input | 1 | Low: load new address, high: advance burst |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| lane_wr_n | input | LANES | Per-lane write mask, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Data bus as seen at the pins (write data) |
| dq_out | output | LANES*LANE_W | Read data driven to the bus |
| dq_drive | output | 1 | High when the block drives the bus |

## Verification
The bench builds the block with its defaults: 8 address bits, 9-bit lanes and two lanes. The lane split therefore matches an 18-bit bus, and the base of a four-beat burst can sit at any offset within its aligned group. The small address space lets directed sequences revisit a handful of words so that bypass hits, partial-lane merges and empty-mask writes can each be observed at the read port. Because two lanes are present, a single-lane write leaves the other lane intact, and that can be detected.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        logic [1:0] sum;
        sum = base + beat;
        return ilv ? (base ^ beat) : sum;
    endfunction

endpackage

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_lane_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane_en[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/zt_cmd_ctrl.sv
module zt_cmd_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_hold,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr
);
    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
        op_e               op;
        logic [ADDR_W-1:0] op_addr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic       selected;
    logic [1:0] beat_nxt;

    assign selected = !cs_a_n && cs_b && !cs_c_n;
    assign beat_nxt = ctl_q.beat + 2'd1;

    always_comb begin
        ctl_d = ctl_q;
        if (!clk_hold) begin
            ctl_d.op = OP_NONE;
            if (!load_n) begin
                if (selected) begin
                    ctl_d.act     = 1'b1;
                    ctl_d.wr      = !wr_n;
                    ctl_d.base    = addr;
                    ctl_d.beat    = 2'd0;
                    ctl_d.op      = wr_n ? OP_READ : OP_WRITE;
                    ctl_d.op_addr = addr;
                end else begin
                    ctl_d.act = 1'b0;
                end
            end else if (ctl_q.act) begin
                ctl_d.beat    = beat_nxt;
                ctl_d.op      = ctl_q.wr ? OP_WRITE : OP_READ;
                ctl_d.op_addr = {ctl_q.base[ADDR_W-1:2],
                                 beat_low(ctl_q.base[1:0], beat_nxt, burst_ilv)};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign s1_op   = ctl_q.op;
    assign s1_addr = ctl_q.op_addr;

endmodule

// File: rtl/zt_data_pipe.sv
module zt_data_pipe
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_hold,
    input  op_e                     s1_op,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic [LANES*LANE_W-1:0] rd_word,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic [LANES-1:0]        lane_wr_n,
    output logic                    commit_en,
    output logic [ADDR_W-1:0]       commit_addr,
    output logic [LANES-1:0]        commit_lanes,
    output logic [LANES*LANE_W-1:0] out_q,
    output logic                    drv_q
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic [DATA_W-1:0] out;
        logic              drv;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic              hit;
    logic [DATA_W-1:0] merged;

    assign hit = (pp_q.s2_op == OP_WRITE) && (pp_q.s2_addr == s1_addr);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            merged[l*LANE_W +: LANE_W] = (hit && !lane_wr_n[l])
                                         ? dq_in[l*LANE_W +: LANE_W]
                                         : rd_word[l*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        pp_d = pp_q;
        if (!clk_hold) begin
            pp_d.s2_op   = s1_op;
            pp_d.s2_addr = s1_addr;
            pp_d.drv     = (s1_op == OP_READ);
            if (s1_op == OP_READ) begin
                pp_d.out = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign commit_en    = !clk_hold && (pp_q.s2_op == OP_WRITE);
    assign commit_addr  = pp_q.s2_addr;
    assign commit_lanes = ~lane_wr_n;
    assign out_q        = pp_q.out;
    assign drv_q        = pp_q.drv;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_hold,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_n,
    input  logic                    load_n,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] rd_word;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [LANES-1:0]  commit_lanes;
    logic [DATA_W-1:0] out_q;
    logic              drv_q;

    zt_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_hold  (clk_hold),
        .load_n    (load_n),
        .wr_n      (wr_n),
        .cs_a_n    (cs_a_n),
        .cs_b      (cs_b),
        .cs_c_n    (cs_c_n),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr)
    );

    zt_data_pipe #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_hold     (clk_hold),
        .s1_op        (s1_op),
        .s1_addr      (s1_addr),
        .rd_word      (rd_word),
        .dq_in        (dq_in),
        .lane_wr_n    (lane_wr_n),
        .commit_en    (commit_en),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .out_q        (out_q),
        .drv_q        (drv_q)
    );

    zt_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk        (clk),
        .wr_en      (commit_en),
        .wr_lane_en (commit_lanes),
        .wr_addr    (commit_addr),
        .wr_data    (dq_in),
        .rd_addr    (s1_addr),
        .rd_data    (rd_word)
    );

    assign dq_out   = out_q;
    assign dq_drive = drv_q && !out_en_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_hold,
    input logic              load_n,
    input logic              cs_a_n,
    input logic              cs_b,
    input logic              cs_c_n,
    input logic              out_en_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive,
    input op_e               s1_op,
    input logic              drv_q
);
    a_r1_read_reaches_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && s1_op == OP_READ) |=> drv_q);

    a_r8_write_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && s1_op == OP_WRITE) |=> !drv_q);

    a_r6_hold_freezes_output: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |=> ($stable(dq_out) && $stable(drv_q)));

    a_r7_deselect_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && !load_n && (cs_a_n || !cs_b || cs_c_n)) |=> (s1_op == OP_NONE));

    a_r11_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_hold && load_n && s1_op == OP_NONE) |=> (s1_op == OP_NONE));

    a_r9_oe_gates_bus: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_drive);

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_hold (clk_hold),
    .load_n   (load_n),
    .cs_a_n   (cs_a_n),
    .cs_b     (cs_b),
    .cs_c_n   (cs_c_n),
    .out_en_n (out_en_n),
    .dq_out   (dq_out),
    .dq_drive (dq_drive),
    .s1_op    (s1_op),
    .drv_q    (drv_q)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_hold = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_n = 1'b1;
    logic        load_n = 1'b0;
    logic        cs_a_n = 1'b1;
    logic        cs_b = 1'b0;
    logic        cs_c_n = 1'b1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic        burst_ilv = 1'b0;
    logic        out_en_n = 1'b0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    zt_sram dut (
        .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .addr(addr), .wr_n(wr_n),
        .load_n(load_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .lane_wr_n(lane_wr_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    // {wr, addr[7:0], data[17:0], lane_wr_n[1:0], expected[17:0]}
    localparam int NV = 16;
    localparam logic [46:0] TBL [NV] = '{
        {1'b1, 8'h10, 18'h12345, 2'b00, 18'h00000},
        {1'b1, 8'h11, 18'h0ABCD, 2'b00, 18'h00000},
        {1'b0, 8'h10, 18'h00000, 2'b11, 18'h12345},
        {1'b1, 8'h10, 18'h3FFFF, 2'b10, 18'h00000},
        {1'b0, 8'h10, 18'h00000, 2'b11, 18'h123FF},
        {1'b0, 8'h11, 18'h00000, 2'b11, 18'h0ABCD},
        {1'b1, 8'h20, 18'h2AAAA, 2'b00, 18'h00000},
        {1'b0, 8'h20, 18'h00000, 2'b11, 18'h2AAAA},
        {1'b1, 8'h20, 18'h15555, 2'b01, 18'h00000},
        {1'b0, 8'h20, 18'h00000, 2'b11, 18'h154AA},
        {1'b1, 8'h11, 18'h3FFFF, 2'b11, 18'h00000},
        {1'b0, 8'h11, 18'h00000, 2'b11, 18'h0ABCD},
        {1'b0, 8'h20, 18'h00000, 2'b11, 18'h154AA},
        {1'b1, 8'h10, 18'h00001, 2'b00, 18'h00000},
        {1'b0, 8'h10, 18'h00000, 2'b11, 18'h00001},
        {1'b0, 8'h10, 18'h00000, 2'b11, 18'h00001}
    };

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs, pass the rising edge, return at the falling edge.
    task automatic cyc(input logic ld_n, input logic sel, input logic wrn,
                       input logic [7:0] a, input logic [17:0] wd, input logic [1:0] bs);
        load_n    = ld_n;
        cs_a_n    = !sel;
        cs_b      = sel;
        cs_c_n    = !sel;
        wr_n      = wrn;
        addr      = a;
        dq_in     = wd;
        lane_wr_n = bs;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [17:0] wd, input logic [1:0] bs);
        cyc(1'b0, 1'b0, 1'b1, 8'h00, wd, bs);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 drive in reset", {17'd0, dq_drive}, 18'd0);
        rst_n = 1'b1;
        idle(18'd0, 2'b11);
        idle(18'd0, 2'b11);
        chk("R12 drive after reset", {17'd0, dq_drive}, 18'd0);

        // Table: back-to-back mixed traffic (R1 R2 R3 R4 R5 R8)
        for (int j = 0; j < NV + 2; j++) begin
            logic [17:0] wd;
            logic [1:0]  bs;
            wd = '0;
            bs = 2'b11;
            if (j >= 2) begin
                logic [46:0] v;
                v = TBL[j-2];
                if (v[46]) begin
                    chk($sformatf("R8 write slot released entry %0d", j-2),
                        {17'd0, dq_drive}, 18'd0);
                    wd = v[37:20];
                    bs = v[19:18];
                end else begin
                    chk($sformatf("R1 read drives entry %0d", j-2),
                        {17'd0, dq_drive}, 18'd1);
                    chk($sformatf("R2 R3 R4 R5 read data entry %0d", j-2),
                        dq_out, v[17:0]);
                end
            end
            if (j < NV) begin
                logic [46:0] c;
                c = TBL[j];
                cyc(1'b0, 1'b1, !c[46], c[45:38], wd, bs);
            end else begin
                idle(wd, bs);
            end
        end

        // R7: deselected write has no effect, bus released in its slot
        cyc(1'b0, 1'b0, 1'b0, 8'h10, 18'h0, 2'b11);
        cyc(1'b0, 1'b1, 1'b1, 8'h10, 18'h0, 2'b11);
        chk("R7 deselect slot released", {17'd0, dq_drive}, 18'd0);
        idle(18'h3FFFF, 2'b00);
        chk("R7 deselected write ignored", dq_out, 18'h00001);
        idle(18'd0, 2'b11);
        chk("R7 bus off after deselect", {17'd0, dq_drive}, 18'd0);

        // R6: stall freezes pipeline and ignores inputs
        cyc(1'b0, 1'b1, 1'b1, 8'h11, 18'd0, 2'b11);
        clk_hold = 1'b1;
        for (int h = 0; h < 3; h++) begin
            cyc(1'b0, 1'b1, 1'b0, 8'h11, 18'h00000, 2'b00);
            chk("R6 frozen before output", {17'd0, dq_drive}, 18'd0);
        end
        clk_hold = 1'b0;
        idle(18'd0, 2'b11);
        chk("R6 read after stall drive", {17'd0, dq_drive}, 18'd1);
        chk("R6 read after stall data", dq_out, 18'h0ABCD);
        clk_hold = 1'b1;
        idle(18'd0, 2'b11);
        idle(18'd0, 2'b11);
        chk("R6 output held drive", {17'd0, dq_drive}, 18'd1);
        chk("R6 output held data", dq_out, 18'h0ABCD);
        clk_hold = 1'b0;
        idle(18'd0, 2'b11);
        chk("R6 released after stall", {17'd0, dq_drive}, 18'd0);
        cyc(1'b0, 1'b1, 1'b1, 8'h11, 18'd0, 2'b11);
        idle(18'd0, 2'b11);
        chk("R6 stalled write ignored", dq_out, 18'h0ABCD);

        // R9: asynchronous output enable
        out_en_n = 1'b1;
        #1;
        chk("R9 oe high forces off", {17'd0, dq_drive}, 18'd0);
        out_en_n = 1'b0;
        #1;
        chk("R9 oe low restores", {17'd0, dq_drive}, 18'd1);
        idle(18'd0, 2'b11);

        // R11: advance with no active burst starts nothing
        cyc(1'b1, 1'b1, 1'b1, 8'h10, 18'd0, 2'b11);
        cyc(1'b1, 1'b1, 1'b1, 8'h10, 18'd0, 2'b11);
        chk("R11 idle advance no read", {17'd0, dq_drive}, 18'd0);
        idle(18'd0, 2'b11);
        chk("R11 idle advance no read 2", {17'd0, dq_drive}, 18'd0);

        // R10: linear write burst at 0x41 -> 41,42,43,40 get 101,102,103,104
        burst_ilv = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 8'h41, 18'd0, 2'b11);
        cyc(1'b1, 1'b1, 1'b0, 8'h00, 18'd0, 2'b11);
        cyc(1'b1, 1'b1, 1'b0, 8'h00, 18'h00101, 2'b00);
        cyc(1'b1, 1'b1, 1'b0, 8'h00, 18'h00102, 2'b00);
        // interleaved read burst at 0x41 -> 41,40,43,42
        burst_ilv = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 8'h41, 18'h00103, 2'b00);
        cyc(1'b1, 1'b1, 1'b1, 8'h00, 18'h00104, 2'b00);
        chk("R10 R3 ilv beat0", dq_out, 18'h00101);
        cyc(1'b1, 1'b1, 1'b1, 8'h00, 18'd0, 2'b11);
        chk("R10 ilv beat1", dq_out, 18'h00104);
        cyc(1'b1, 1'b1, 1'b1, 8'h00, 18'd0, 2'b11);
        chk("R10 ilv beat2", dq_out, 18'h00103);
        idle(18'd0, 2'b11);
        chk("R10 ilv beat3", dq_out, 18'h00102);
        idle(18'd0, 2'b11);
        chk("R7 burst ended by deselect", {17'd0, dq_drive}, 18'd0);

        // linear read burst at 0x43 -> 43,40,41,42; selects inactive on advances (R11)
        burst_ilv = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 8'h43, 18'd0, 2'b11);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, 18'd0, 2'b11);
        chk("R10 lin beat0", dq_out, 18'h00103);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, 18'd0, 2'b11);
        chk("R10 R11 lin beat1", dq_out, 18'h00104);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, 18'd0, 2'b11);
        chk("R10 R11 lin beat2", dq_out, 18'h00101);
        idle(18'd0, 2'b11);
        chk("R10 R11 lin beat3 drive", {17'd0, dq_drive}, 18'd1);
        chk("R10 R11 lin beat3", dq_out, 18'h00102);
        idle(18'd0, 2'b11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule